// File: doc/BRIEF.md
# Serial Byte Receiver with Centre Sampling

This block takes asynchronous serial frames on one input line and turns each one into a parallel byte for a host on a memory-mapped bus. A frame is one start bit (low), eight data bits with the least significant bit first, and one stop bit (high). There is no parity bit. The line is idle high. One parameter sets the bit period, counted in clocks. Every sampling instant is derived from that count.

The line first passes through a two-flop synchronizer. A falling edge on the synchronized line starts a frame. The receiver then waits half a bit period and checks that the start bit is still low. A line that has gone high again counts as noise, and the receiver goes back to idle. Otherwise it samples each data bit one full period after the one before. The first data sample therefore lands one and a half periods after the edge, at the centre of that bit. Bits enter from the top of a right-shifting register, which is the mirror image of a transmitter that shifts out of bit 0.

A byte with a good stop bit is written to the data output and raises a sticky valid flag. The host clears the flag with a one-cycle read strobe. The valid flag also appears as bit 1 of a status byte.

Top module: `serial_byte_rx`

## Requirements
- R1: Each bit is sampled at its centre. With a bit period of P clocks, the first data sample is taken (P + P/2) clocks after the start edge, and each later sample follows the previous one by P clocks. A byte whose data bits have their first two and last two clocks inverted is therefore still received correctly.
- R2: Data bits arrive least significant bit first. After a frame with a high stop bit, `rd_data` holds the eight received bits with the first bit received in bit 0.
- R3: `rx_valid` goes high when a byte completes. It stays high until `rd_clear` is asserted.
- R4: A one-cycle `rd_clear` drives `rx_valid` low from the next cycle on and leaves `rd_data` unchanged.
- R5: A frame whose stop bit samples low is discarded. `rd_data` and `rx_valid` keep their previous values.
- R6: A low pulse on the line that is gone before the mid-start-bit check produces no byte. A frame sent afterwards is received normally.
- R7: A byte that completes while `rx_valid` is still high replaces `rd_data`, and `rx_valid` stays high.
- R8: `status` is `{6'b0, rx_valid, 1'b0}`: the valid flag is bit 1 and all other bits are 0.
- R9: After reset, `rd_data` is 0, `rx_valid` is 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial line, idle high |
| rd_clear | input | 1 | Host read strobe; clears the valid flag |
| rd_data | output | 8 | Last byte received |
| rx_valid | output | 1 | Sticky flag: a byte is waiting |
| status | output | 8 | Status byte, valid flag in bit 1 |

## Verification
Plain frames with the values 0x5A, 0x01 and 0x80 check the bit order, because a reversed shift would swap the isolated end bits. A frame whose data bits are corrupted near their edges separates centre sampling from sampling at the start or end of a bit. Frames with a low stop bit, short low pulses, back-to-back bytes without a read, and read strobes test discarding, noise rejection, overwriting and clearing. After each of these, the data and status outputs are checked.

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int BIT_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx,
  input  logic       rd_clear,
  output logic [7:0] rd_data,
  output logic       rx_valid,
  output logic [7:0] status
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = $clog2(BIT_CLKS + 1);
  localparam logic [CW-1:0] FULL_LD = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_LD = CW'(HALF - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [2:0]    sync_q;
  logic [CW-1:0] tmr;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;

  wire line      = sync_q[1];
  wire fall      = !sync_q[1] && sync_q[2];
  wire tick      = (tmr == '0);
  wire byte_done = (st == S_STOP) && tick && line;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else begin
      case (st)
        S_IDLE: if (fall) begin
          st  <= S_START;
          tmr <= HALF_LD;
        end
        S_START: begin
          if (!tick) tmr <= tmr - 1'b1;
          else if (!line) begin
            st      <= S_DATA;
            tmr     <= FULL_LD;
            bit_idx <= '0;
          end else st <= S_IDLE;
        end
        S_DATA: begin
          if (!tick) tmr <= tmr - 1'b1;
          else begin
            shreg   <= {line, shreg[7:1]};
            tmr     <= FULL_LD;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) st <= S_STOP;
          end
        end
        S_STOP: begin
          if (!tick) tmr <= tmr - 1'b1;
          else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (byte_done) rd_data <= shreg;
      if (byte_done)     rx_valid <= 1'b1;
      else if (rd_clear) rx_valid <= 1'b0;
    end
  end

  assign status = {6'b0, rx_valid, 1'b0};
endmodule

// File: rtl/serial_byte_rx_checks.sv
module serial_byte_rx_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_clear,
  input logic [7:0] rd_data,
  input logic       rx_valid,
  input logic [7:0] status,
  input logic       byte_done
);
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rd_clear |=> rx_valid);
  a_r3_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_valid);
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear && !byte_done |=> !rx_valid);
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rd_data));
  a_r3_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid && !byte_done |=> !rx_valid);
  a_r8_status_map: assert property (@(posedge clk) disable iff (!rst_n)
    status == {6'b0, rx_valid, 1'b0});
endmodule

bind serial_byte_rx serial_byte_rx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .rd_clear(rd_clear), .rd_data(rd_data),
  .rx_valid(rx_valid), .status(status), .byte_done(byte_done)
);

// File: tb/serial_byte_rx_tb_top.sv
module serial_byte_rx_tb_top;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       rd_clear = 1'b0;
  logic [7:0] rd_data;
  logic       rx_valid;
  logic [7:0] status;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  serial_byte_rx #(.BIT_CLKS(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx(rx), .rd_clear(rd_clear),
    .rd_data(rd_data), .rx_valid(rx_valid), .status(status)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input bit shaped);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      rx = (shaped && (i < 2 || i >= P - 2)) ? ~b : b;
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic stop, input bit shaped);
    drive_bit(1'b0, 1'b0);
    for (int k = 0; k < 8; k++) drive_bit(d[k], shaped);
    drive_bit(stop, 1'b0);
    @(negedge clk);
    rx = 1'b1;
    repeat (2 * P) @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk); rd_clear = 1'b1;
    @(negedge clk); rd_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 data", rd_data, 8'h00);
    check("R9 valid", {7'b0, rx_valid}, 8'h00);
    check("R9 status", status, 8'h00);
  endtask

  task automatic t_basic();
    send_byte(8'h5A, 1'b1, 1'b0);
    check("R2 byte 5A", rd_data, 8'h5A);
    check("R3 valid set", {7'b0, rx_valid}, 8'h01);
    check("R8 status valid", status, 8'h02);
    host_read();
    send_byte(8'h01, 1'b1, 1'b0);
    check("R2 byte 01", rd_data, 8'h01);
    host_read();
    send_byte(8'h80, 1'b1, 1'b0);
    check("R2 byte 80", rd_data, 8'h80);
    host_read();
  endtask

  task automatic t_center();
    send_byte(8'hA5, 1'b1, 1'b1);
    check("R1 centre A5", rd_data, 8'hA5);
    host_read();
    send_byte(8'h3C, 1'b1, 1'b1);
    check("R1 centre 3C", rd_data, 8'h3C);
    host_read();
  endtask

  task automatic t_sticky_clear();
    send_byte(8'hC3, 1'b1, 1'b0);
    repeat (5 * P) @(negedge clk);
    check("R3 still valid", {7'b0, rx_valid}, 8'h01);
    host_read();
    check("R4 valid cleared", {7'b0, rx_valid}, 8'h00);
    check("R4 data kept", rd_data, 8'hC3);
    check("R8 status cleared", status, 8'h00);
  endtask

  task automatic t_overwrite();
    send_byte(8'h11, 1'b1, 1'b0);
    send_byte(8'hE7, 1'b1, 1'b0);
    check("R7 overwritten", rd_data, 8'hE7);
    check("R7 valid high", {7'b0, rx_valid}, 8'h01);
    host_read();
  endtask

  task automatic t_frame_err();
    send_byte(8'h96, 1'b0, 1'b0);
    check("R5 data kept", rd_data, 8'hE7);
    check("R5 no valid", {7'b0, rx_valid}, 8'h00);
  endtask

  task automatic t_glitch();
    @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b1;
    repeat (3 * P) @(negedge clk);
    check("R6 no byte", {7'b0, rx_valid}, 8'h00);
    check("R6 data kept", rd_data, 8'hE7);
    send_byte(8'h4B, 1'b1, 1'b0);
    check("R6 next byte", rd_data, 8'h4B);
    host_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_basic();
    t_center();
    t_sticky_clear();
    t_overwrite();
    t_frame_err();
    t_glitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule